// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is an 8-bit clocked serial port for a small microcontroller. One shift register does both jobs in a transfer. Its top bit drives the serial output, and each bit sampled from the serial input enters at the bottom. After eight bit times the register holds the received byte, and every bit of the byte that was loaded has been sent.

The port can run as master or as slave. As master it makes the serial clock from the system clock at one of three rates, drives it out, and parks it low when the transfer ends. As slave it takes the serial clock from an outside device through a two-flop synchronizer. After the eighth bit it ignores any further edges until software starts a new transfer.

Software uses a small write/read register port with three addresses: control, data and status. It loads a byte, writes the start bit, and then waits for the busy flag to drop or for the completion interrupt. The busy flag is also brought out on a pin, so that an outside master can tell whether the port is ready.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the clock select field reads 11 (slave), interrupt enable reads 0, busy and the interrupt flag read 0, and sclkOut, irqOut and busyOut are 0. The control register is at address 0: bits [1:0] are the clock select, bit 2 is the interrupt enable, bit 3 is start (write) or busy (read), and bit 4 is the interrupt flag (read).
- R2: Clock select 00 gives a master SCLK period of 2 system cycles, 01 gives 4, 10 gives 8, and 11 selects slave mode.
- R3: In master mode a transfer drives exactly 8 SCLK rising edges, after which sclkOut stays low for as long as the port is idle.
- R4: Data leaves MSB first. SOUT changes only after a falling SCLK edge and is steady at each rising edge, where SIN is sampled. When the transfer ends, the data register (address 1) holds the received byte, MSB first.
- R5: In slave mode the eighth synchronized falling edge of sclkIn ends the transfer. Later edges change neither the data register nor busy.
- R6: Writing 1 to start sets busy, which shows on busyOut and on status bit 0 (address 2). Busy clears when the eighth bit completes.
- R7: While busy, writes to the data register and to the clock select field are ignored.
- R8: Completion sets the interrupt flag (status bit 1). irqOut is the flag ANDed with the interrupt enable. Writing 1 to status bit 0 clears the flag.
- R9: In slave mode sclkOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 data, 2 status) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for addr (combinational) |
| sinIn | input | 1 | Serial data input |
| sclkIn | input | 1 | External serial clock (slave mode) |
| soutOut | output | 1 | Serial data output |
| sclkOut | output | 1 | Generated serial clock (master mode) |
| busyOut | output | 1 | Transfer in progress |
| irqOut | output | 1 | Completion interrupt request |

## Verification
The hardest case to reach is a slave transfer that receives extra clock edges after the eighth bit, together with writes that arrive while the port is busy. The external clock crosses a synchronizer, so the bench has to allow for that delay. It holds each external clock phase for five system cycles and drives the input bit at the same time as the falling edge. During one slave transfer it writes a new byte and a master rate in the middle of the transfer, and after the transfer it sends three extra pulses carrying different data. It then shows through the data register, the control readback and the pins that none of these had any effect. The master side is swept over all three rates with a dozen byte pairs, and the bench measures the SCLK period and counts the edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SEL_FULL = 2'b00,
    SEL_DIV2 = 2'b01,
    SEL_DIV4 = 2'b10,
    SEL_EXT  = 2'b11
  } clk_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // parallel load of the shift register
    logic capture;  // sample serial input (rising serial clock)
    logic shift;    // advance the shift register (falling serial clock)
    logic useSync;  // take the synchronized serial input (slave mode)
  } dp_strobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sinIn,
  output logic [DATA_W-1:0] shiftReg,
  output logic              soutOut
);
  logic sinSync;
  logic sinBit;
  logic sampled;

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sinSync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sinIn),
    .q    (sinSync)
  );

  assign sinBit = strobe.useSync ? sinSync : sinIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sampled <= 1'b0;
    else if (strobe.capture) sampled <= sinBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '0;
    else if (strobe.load) shiftReg <= wrData;
    else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampled};
  end

  assign soutOut = shiftReg[DATA_W-1];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DATA_W + 1),
  localparam int unsigned DIV_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclkIn,
  output dp_strobe_t        strobe,
  output clk_sel_e          clkSel,
  output logic              irqEn,
  output logic              busy,
  output logic              irqFlag,
  output logic              sclkOut,
  output logic [CNT_W-1:0]  bitCnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             isSlave;
  logic             wrCtrl;
  logic             wrData_;
  logic             wrStat;
  logic             startReq;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             sclkReg;
  logic             sclkSync;
  logic             sclkPrev;
  logic             extRise;
  logic             extFall;
  logic             doCapture;
  logic             doShift;
  logic             lastShift;

  assign isSlave  = (clkSel == SEL_EXT);
  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);
  assign wrData_  = wrEn && (addr == ADDR_DATA);
  assign wrStat   = wrEn && (addr == ADDR_STAT);
  assign startReq = wrCtrl && !busy && wrData[3];

  // free-running divider for the slower master rates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    unique case (clkSel)
      SEL_FULL: tick = 1'b1;
      SEL_DIV2: tick = divCnt[0];
      SEL_DIV4: tick = &divCnt;
      default:  tick = 1'b0;
    endcase
  end

  // external clock synchronizer and edge detect
  ssp_sync #(.STAGES(SYNC_STAGES)) u_sclkSync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sclkIn),
    .q    (sclkSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclkPrev <= 1'b0;
    else sclkPrev <= sclkSync;
  end

  assign extRise = sclkSync && !sclkPrev;
  assign extFall = !sclkSync && sclkPrev;

  always_comb begin
    doCapture = 1'b0;
    doShift   = 1'b0;
    if (busy) begin
      if (isSlave) begin
        doCapture = extRise;
        doShift   = extFall;
      end else if (tick) begin
        doCapture = !sclkReg;
        doShift   = sclkReg;
      end
    end
  end

  assign lastShift = doShift && (bitCnt == LAST_BIT);

  // configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSel <= SEL_EXT;
      irqEn  <= 1'b0;
    end else if (wrCtrl) begin
      irqEn <= wrData[2];
      if (!busy) clkSel <= clk_sel_e'(wrData[1:0]);
    end
  end

  // transfer sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (startReq) begin
      busy    <= 1'b1;
      bitCnt  <= '0;
      sclkReg <= 1'b0;
    end else begin
      if (doCapture && !isSlave) sclkReg <= 1'b1;
      if (doShift) begin
        sclkReg <= 1'b0;
        bitCnt  <= bitCnt + 1'b1;
      end
      if (lastShift) busy <= 1'b0;
    end
  end

  // completion flag: setting wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqFlag <= 1'b0;
    else if (lastShift) irqFlag <= 1'b1;
    else if (wrStat && wrData[0]) irqFlag <= 1'b0;
  end

  assign sclkOut = sclkReg && !isSlave;

  assign strobe.load    = wrData_ && !busy;
  assign strobe.capture = doCapture;
  assign strobe.shift   = doShift;
  assign strobe.useSync = isSlave;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sinIn,
  input  logic              sclkIn,
  output logic              soutOut,
  output logic              sclkOut,
  output logic              busyOut,
  output logic              irqOut
);
  dp_strobe_t        strobes;
  clk_sel_e          clkSel;
  logic              irqEn;
  logic              busy;
  logic              irqFlag;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;

  ssp_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .sclkIn (sclkIn),
    .strobe (strobes),
    .clkSel (clkSel),
    .irqEn  (irqEn),
    .busy   (busy),
    .irqFlag(irqFlag),
    .sclkOut(sclkOut),
    .bitCnt (bitCnt)
  );

  ssp_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobes),
    .wrData  (wrData),
    .sinIn   (sinIn),
    .shiftReg(shiftReg),
    .soutOut (soutOut)
  );

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: rdData[4:0] = {irqFlag, busy, irqEn, clkSel};
      ADDR_DATA: rdData      = shiftReg;
      ADDR_STAT: rdData[1:0] = {irqFlag, busy};
      default:   rdData      = '0;
    endcase
  end

  assign busyOut = busy;
  assign irqOut  = irqFlag && irqEn;
endmodule

// File: rtl/sync_serial_port_chk.sv
module sync_serial_port_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irqFlag,
  input logic [1:0]        clkSel,
  input logic              sclkOut,
  input logic              shiftStb,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [DATA_W-1:0] shiftReg
);
  p_sclk_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclkOut);

  p_sclk_quiet_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clkSel == 2'b11) |-> !sclkOut);

  p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(clkSel));

  p_data_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shiftStb) |=> $stable(shiftReg));

  p_bit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_W'(DATA_W));

  p_done_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irqFlag);
endmodule

bind sync_serial_port sync_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .irqFlag (irqFlag),
  .clkSel  (clkSel),
  .sclkOut (sclkOut),
  .shiftStb(strobes.shift),
  .bitCnt  (bitCnt),
  .shiftReg(shiftReg)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
  localparam int HALF = 5;   // slave clock half period in system cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sinIn = 1'b0;
  logic       sclkIn = 1'b0;
  logic       soutOut, sclkOut, busyOut, irqOut;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sinIn(sinIn), .sclkIn(sclkIn), .soutOut(soutOut),
    .sclkOut(sclkOut), .busyOut(busyOut), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic runMaster(input int sel, input logic [7:0] tx, input logic [7:0] rx,
                           input bit ien);
    logic [7:0] got = '0;
    logic [7:0] rv;
    int rises = 0, falls = 0, badPeriod = 0, lastRise = 0, cyc = 0, extra = 0;
    bit prevS = 1'b0;
    regWrite(2'd1, tx);
    sinIn = rx[7];
    regWrite(2'd0, {4'b0000, 1'b1, ien, sel[1:0]});
    check(busyOut == 1'b1, "R6 busy after start", busyOut, 1);
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      cyc++;
      if (sclkOut && !prevS) begin
        if (rises > 0 && (cyc - lastRise) != (2 << sel)) badPeriod++;
        lastRise = cyc;
        rises++;
        got = {got[6:0], soutOut};
      end
      if (!sclkOut && prevS) begin
        falls++;
        if (falls < 8) sinIn = rx[7 - falls];
      end
      prevS = sclkOut;
      if (!busyOut) break;
    end
    check(busyOut == 1'b0, "R6 busy cleared", busyOut, 0);
    check(rises == 8, "R3 rising edge count", rises, 8);
    check(badPeriod == 0, "R2 SCLK period", badPeriod, 0);
    check(got == tx, "R4 transmitted byte", got, tx);
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      if (sclkOut) extra++;
    end
    check(extra == 0, "R3 SCLK parked low", extra, 0);
    regRead(2'd1, rv);
    check(rv == rx, "R4 received byte", rv, rx);
    regRead(2'd2, rv);
    check(rv[1] == 1'b1, "R8 flag set", rv[1], 1);
    check(irqOut == ien, "R8 irq gated by enable", irqOut, ien);
    regWrite(2'd2, 8'h01);
    regRead(2'd2, rv);
    check(rv[1] == 1'b0 && irqOut == 1'b0, "R8 flag cleared", rv, 0);
  endtask

  task automatic runSlave(input logic [7:0] tx, input logic [7:0] rx, input bit lockTest);
    logic [7:0] got = '0;
    logic [7:0] rv;
    int sclkSeen = 0;
    regWrite(2'd1, tx);
    sinIn = rx[7];
    sclkIn = 1'b0;
    regWrite(2'd0, 8'h0F);
    check(busyOut == 1'b1, "R6 slave busy after start", busyOut, 1);
    for (int i = 0; i < 8; i++) begin
      repeat (HALF) begin
        @(negedge clk);
        if (sclkOut) sclkSeen++;
      end
      got[7 - i] = soutOut;
      sclkIn = 1'b1;
      repeat (HALF) @(negedge clk);
      sclkIn = 1'b0;
      if (i < 7) sinIn = rx[6 - i];
      if (lockTest && i == 0) begin
        regWrite(2'd1, 8'h5A);
        regWrite(2'd0, 8'h04);
        regRead(2'd0, rv);
        check(rv[1:0] == 2'b11, "R7 select locked while busy", rv[1:0], 3);
      end
    end
    repeat (HALF) @(negedge clk);
    check(busyOut == 1'b0, "R5 busy cleared after eighth edge", busyOut, 0);
    check(got == tx, "R4 slave transmitted byte", got, tx);
    check(sclkSeen == 0, "R9 no SCLK output in slave", sclkSeen, 0);
    regRead(2'd1, rv);
    check(rv == rx, "R5 slave received byte", rv, rx);
    check(irqOut == 1'b1, "R8 slave irq", irqOut, 1);
    regWrite(2'd2, 8'h01);
    for (int p = 0; p < 3; p++) begin
      sinIn = ~sinIn;
      repeat (HALF) @(negedge clk);
      sclkIn = 1'b1;
      repeat (HALF) @(negedge clk);
      sclkIn = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    regRead(2'd1, rv);
    check(rv == rx && busyOut == 1'b0 && irqOut == 1'b0, "R5 extra edges ignored", rv, rx);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    regRead(2'd0, rv);
    check(rv == 8'h03, "R1 control reset value", rv, 8'h03);
    regRead(2'd2, rv);
    check(rv == 8'h00, "R1 status reset value", rv, 0);
    check(sclkOut == 0 && irqOut == 0 && busyOut == 0, "R1 pins at reset",
          {sclkOut, irqOut, busyOut}, 0);

    for (int sel = 0; sel < 3; sel++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] tx, rx;
        tx = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h80 : 8'(k * 37 + 5);
        rx = (k == 0) ? 8'hFF : (k == 1) ? 8'h01 : 8'(~tx ^ (k * 11));
        runMaster(sel, tx, rx, k[0]);
      end
    end

    for (int k = 0; k < 10; k++) begin
      logic [7:0] tx, rx;
      tx = 8'(k * 53 + 9);
      rx = 8'(k * 29 + 200);
      runSlave(tx, rx, k == 3);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule